// File: doc/BRIEF.md
# Streaming Link Protocol Rule Checker

This block is a passive observer for one AXI4-Stream link. It takes the payload, the valid and ready handshake bits, the end-of-packet marker and the two per-lane byte qualifiers (the lane-occupied mask and the lane-carries-data mask) as inputs. It drives none of them. On every clock edge it checks four rules. The payload and sidebands must hold still while a beat is stalled. A lane may not claim to carry data while it is marked unoccupied. Unoccupied lanes may appear only on the closing beat of a packet. A beat must not be completely empty.

Each rule has a sticky flag that stays set until a synchronous clear. A one-cycle pulse reports the code of the rule that fired, and a register holds the code of the first violation seen since the last clear or reset. The checker samples the valid bit on every cycle. Ready never gates it, so the sender's behaviour is judged on its own. A parameter removes the lane-carries-data mask from all checks for links that do not carry it.

Top module: `strm_rule_chk`

## Requirements
- R1: A beat is transferred only on a rising edge where valid and ready are both high. A stall is tracked only after an edge with valid high and ready low. After a transferred beat, the next beat may differ freely without any error.
- R2: After an edge with valid high and ready low, any change on the next edge raises rule code 1 (stability). This covers payload, end marker, either lane mask, or valid falling. Ready plays no part in whether valid is sampled.
- R3: On a valid beat, a lane with the data mask bit at 1 and the occupied mask bit at 0 raises rule code 2. The same lane pattern on a beat with valid low raises nothing.
- R4: On a valid beat with the end marker low, any lane with occupied bit 0 raises rule code 3. On a valid beat with the end marker high, such lanes raise nothing.
- R5: A valid beat whose occupied mask is all zeros raises rule code 4. This applies whether or not the end marker is high.
- R6: With HAS_STRB = 0, the data mask input is ignored by rule 2 and by the stability rule.
- R7: One cycle after the edge that sampled a violation, err_pulse is high for one cycle. In that cycle err_code holds the smallest violated code. err_flags bit (code-1) is set for every violated rule (bit 0 = code 1 ... bit 3 = code 4).
- R8: err_flags bits stay set until clr is sampled high. clr clears them, but a violation sampled on the same edge as clr is still recorded.
- R9: first_code holds the code of the first pulse since the last clear or reset. With clr high, it takes that edge's code, or 0 if that edge has no violation.
- R10: While rst_n is low, the bus is ignored. All outputs read 0 one cycle later, and stall tracking is cleared, so a stall before reset cannot cause an error after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of sticky flags and first code |
| bus_data | input | 8*DATA_BYTES | Observed payload |
| bus_vld | input | 1 | Observed valid |
| bus_rdy | input | 1 | Observed ready |
| bus_end | input | 1 | Observed end-of-packet marker |
| bus_lane_keep | input | DATA_BYTES | Observed lane-occupied mask |
| bus_lane_strb | input | DATA_BYTES | Observed lane-carries-data mask |
| err_flags | output | 4 | Sticky per-rule flags, bit i for code i+1 |
| err_pulse | output | 1 | One-cycle violation pulse |
| err_code | output | 3 | Code of the pulse, 0 when idle |
| first_code | output | 3 | First code since clear or reset |

## Verification
The bench builds two copies with DATA_BYTES = 4 that watch the same bus. One has HAS_STRB = 1 and is compared beat by beat against a scoreboard model. The other has HAS_STRB = 0 and must stay silent when the data mask alone breaks a rule. Four lanes are enough to place unoccupied lanes in the low, middle and high positions, and to produce the all-zero mask. Running both variants side by side shows in one run that the data mask can be switched off.

// File: rtl/strm_chk_pkg.sv
`timescale 1ns/1ps
package strm_chk_pkg;

    localparam int NUM_RULES = 4;
    localparam int CODE_W    = 3;

    typedef enum logic [CODE_W-1:0] {
        RC_NONE  = 3'd0,
        RC_STALL = 3'd1,
        RC_PAIR  = 3'd2,
        RC_NULL  = 3'd3,
        RC_EMPTY = 3'd4
    } rule_code_e;

endpackage

// File: rtl/strm_chk_stall.sv
`timescale 1ns/1ps
module strm_chk_stall #(
    parameter int DATA_BYTES = 4,
    parameter bit HAS_STRB   = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [8*DATA_BYTES-1:0] data_i,
    input  logic                    vld_i,
    input  logic                    rdy_i,
    input  logic                    end_i,
    input  logic [DATA_BYTES-1:0]   keep_i,
    input  logic [DATA_BYTES-1:0]   strb_i,
    output logic                    viol_o
);
    localparam int DW = 8 * DATA_BYTES;

    typedef struct packed {
        logic                  hold;
        logic [DW-1:0]         data;
        logic                  last;
        logic [DATA_BYTES-1:0] keep;
        logic [DATA_BYTES-1:0] strb;
    } snap_t;

    snap_t                 st_d, st_q;
    logic [DATA_BYTES-1:0] strb_eff;
    logic                  viol_d;

    // Without the data mask, compare a constant instead of the input
    generate
        if (HAS_STRB) begin : g_cmp_strb
            assign strb_eff = strb_i;
        end else begin : g_skip_strb
            assign strb_eff = '0;
        end
    endgenerate

    always_comb begin
        st_d   = st_q;
        viol_d = st_q.hold && (!vld_i
                             || (data_i   != st_q.data)
                             || (end_i    != st_q.last)
                             || (keep_i   != st_q.keep)
                             || (strb_eff != st_q.strb));
        st_d.hold = vld_i && !rdy_i;
        st_d.data = data_i;
        st_d.last = end_i;
        st_d.keep = keep_i;
        st_d.strb = strb_eff;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign viol_o = viol_d;

    // R1: a stalled beat arms stall tracking for the next edge
    p_stall_armed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !rdy_i) |=> st_q.hold);

    // R1: a completed transfer leaves nothing to compare
    p_xfer_disarms_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld_i || rdy_i) |=> !viol_o);

endmodule

// File: rtl/strm_chk_lanes.sv
`timescale 1ns/1ps
module strm_chk_lanes #(
    parameter int DATA_BYTES = 4,
    parameter bit HAS_STRB   = 1'b1
) (
    input  logic                  vld_i,
    input  logic                  end_i,
    input  logic [DATA_BYTES-1:0] keep_i,
    input  logic [DATA_BYTES-1:0] strb_i,
    output logic                  pair_err_o,
    output logic                  null_err_o,
    output logic                  empty_err_o
);
    logic [DATA_BYTES-1:0] bad_pair;
    logic [DATA_BYTES-1:0] null_lane;

    for (genvar i = 0; i < DATA_BYTES; i++) begin : g_lane
        assign null_lane[i] = !keep_i[i];
        if (HAS_STRB) begin : g_pair
            assign bad_pair[i] = strb_i[i] && !keep_i[i];
        end else begin : g_nopair
            assign bad_pair[i] = 1'b0;
        end
    end

    always_comb begin
        pair_err_o  = vld_i && (|bad_pair);
        null_err_o  = vld_i && !end_i && (|null_lane);
        empty_err_o = vld_i && (&null_lane);
    end

endmodule

// File: rtl/strm_chk_report.sv
`timescale 1ns/1ps
module strm_chk_report
    import strm_chk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic [NUM_RULES-1:0] hits_i,
    output logic [NUM_RULES-1:0] flags_o,
    output logic                 pulse_o,
    output logic [CODE_W-1:0]    code_o,
    output logic [CODE_W-1:0]    first_o
);
    typedef struct packed {
        logic [NUM_RULES-1:0] flags;
        logic                 pulse;
        logic [CODE_W-1:0]    code;
        logic [CODE_W-1:0]    first;
    } rpt_t;

    rpt_t              r_d, r_q;
    logic [CODE_W-1:0] code_now;

    always_comb begin
        code_now = RC_NONE;
        for (int i = NUM_RULES - 1; i >= 0; i--) begin
            if (hits_i[i]) code_now = CODE_W'(i + 1);
        end
        r_d       = r_q;
        r_d.pulse = |hits_i;
        r_d.code  = code_now;
        r_d.flags = (clr_i ? '0 : r_q.flags) | hits_i;
        if (clr_i || (r_q.first == RC_NONE)) r_d.first = code_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign flags_o = r_q.flags;
    assign pulse_o = r_q.pulse;
    assign code_o  = r_q.code;
    assign first_o = r_q.first;

    // R8: flags only grow unless a clear is sampled
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((r_q.flags & $past(r_q.flags)) == $past(r_q.flags)));

    // R9: a recorded first code holds until cleared
    p_first_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.first != RC_NONE && !clr_i) |=> (r_q.first == $past(r_q.first)));

    // R7: a pulse always has its rule flag raised in the same cycle
    p_pulse_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pulse |-> ((r_q.flags & (4'b0001 << (r_q.code - 3'd1))) != 4'b0000));

    // R7: pulse and code agree
    p_pulse_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pulse == (r_q.code != RC_NONE));

endmodule

// File: rtl/strm_rule_chk.sv
`timescale 1ns/1ps
module strm_rule_chk
    import strm_chk_pkg::*;
#(
    parameter int DATA_BYTES = 4,
    parameter bit HAS_STRB   = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic [8*DATA_BYTES-1:0] bus_data,
    input  logic                    bus_vld,
    input  logic                    bus_rdy,
    input  logic                    bus_end,
    input  logic [DATA_BYTES-1:0]   bus_lane_keep,
    input  logic [DATA_BYTES-1:0]   bus_lane_strb,
    output logic [NUM_RULES-1:0]    err_flags,
    output logic                    err_pulse,
    output logic [CODE_W-1:0]       err_code,
    output logic [CODE_W-1:0]       first_code
);
    logic                 stall_viol;
    logic                 pair_err, null_err, empty_err;
    logic [NUM_RULES-1:0] hits;

    strm_chk_stall #(.DATA_BYTES(DATA_BYTES), .HAS_STRB(HAS_STRB)) u_stall (
        .clk    (clk),
        .rst_n  (rst_n),
        .data_i (bus_data),
        .vld_i  (bus_vld),
        .rdy_i  (bus_rdy),
        .end_i  (bus_end),
        .keep_i (bus_lane_keep),
        .strb_i (bus_lane_strb),
        .viol_o (stall_viol)
    );

    strm_chk_lanes #(.DATA_BYTES(DATA_BYTES), .HAS_STRB(HAS_STRB)) u_lanes (
        .vld_i       (bus_vld),
        .end_i       (bus_end),
        .keep_i      (bus_lane_keep),
        .strb_i      (bus_lane_strb),
        .pair_err_o  (pair_err),
        .null_err_o  (null_err),
        .empty_err_o (empty_err)
    );

    // bit i of hits carries rule code i+1
    assign hits = {empty_err, null_err, pair_err, stall_viol};

    strm_chk_report u_report (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .hits_i  (hits),
        .flags_o (err_flags),
        .pulse_o (err_pulse),
        .code_o  (err_code),
        .first_o (first_code)
    );

    // R10: reset leaves every output quiet on the next cycle
    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |=> (err_flags == '0 && !err_pulse && first_code == RC_NONE));

    // R5: an all-empty valid beat is always reported
    p_empty_seen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld && bus_lane_keep == '0) |=> err_flags[3]);

endmodule

// File: tb/strm_rule_chk_bench.sv
`timescale 1ns/1ps
module strm_rule_chk_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic [31:0] bus_data = '0;
    logic        bus_vld = 1'b0, bus_rdy = 1'b0, bus_end = 1'b0;
    logic [3:0]  bus_lane_keep = 4'hF, bus_lane_strb = 4'h0;
    logic [3:0]  err_flags, ns_flags;
    logic        err_pulse, ns_pulse;
    logic [2:0]  err_code, first_code, ns_code, ns_first;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    strm_rule_chk #(.DATA_BYTES(4), .HAS_STRB(1'b1)) u_strm_rule_chk (
        .clk(clk), .rst_n(rst_n), .clr(clr), .bus_data(bus_data),
        .bus_vld(bus_vld), .bus_rdy(bus_rdy), .bus_end(bus_end),
        .bus_lane_keep(bus_lane_keep), .bus_lane_strb(bus_lane_strb),
        .err_flags(err_flags), .err_pulse(err_pulse),
        .err_code(err_code), .first_code(first_code)
    );

    strm_rule_chk #(.DATA_BYTES(4), .HAS_STRB(1'b0)) u_strm_rule_chk_nostrb (
        .clk(clk), .rst_n(rst_n), .clr(clr), .bus_data(bus_data),
        .bus_vld(bus_vld), .bus_rdy(bus_rdy), .bus_end(bus_end),
        .bus_lane_keep(bus_lane_keep), .bus_lane_strb(bus_lane_strb),
        .err_flags(ns_flags), .err_pulse(ns_pulse),
        .err_code(ns_code), .first_code(ns_first)
    );

    // scoreboard: expected {pulse, code, flags, first}
    logic [10:0] exp_q[$];
    string       tag_q[$];

    // requirement model state
    logic        m_hold = 1'b0;
    logic [31:0] m_d;
    logic        m_l;
    logic [3:0]  m_k, m_s;
    logic [3:0]  m_flags = '0;
    logic [2:0]  m_first = '0;

    task automatic monitor_pop();
        logic [10:0] e, got;
        string t;
        if (exp_q.size() > 0) begin
            e   = exp_q.pop_front();
            t   = tag_q.pop_front();
            got = {err_pulse, err_code, err_flags, first_code};
            n_tests++;
            if (got !== e) begin
                n_fail++;
                $display("FAIL %s: got pulse/code/flags/first=%b expected %b", t, got, e);
            end
        end
    endtask

    task automatic step(input logic rn, input logic v, input logic r, input logic l,
                        input logic [31:0] d, input logic [3:0] k, input logic [3:0] s,
                        input logic c, input string tag);
        logic [3:0]  hits;
        logic [2:0]  code;
        logic [10:0] e;
        @(negedge clk);
        monitor_pop();
        rst_n = rn; bus_vld = v; bus_rdy = r; bus_end = l;
        bus_data = d; bus_lane_keep = k; bus_lane_strb = s; clr = c;
        if (!rn) begin
            m_hold = 1'b0; m_flags = '0; m_first = '0; e = '0;
        end else begin
            hits[0] = m_hold && (!v || d != m_d || l != m_l || k != m_k || s != m_s);
            hits[1] = v && (|(s & ~k));
            hits[2] = v && !l && (|(~k));
            hits[3] = v && (k == 4'h0);
            code = 3'd0;
            for (int i = 3; i >= 0; i--) if (hits[i]) code = 3'(i + 1);
            m_flags = (c ? 4'h0 : m_flags) | hits;
            if (c || m_first == 3'd0) m_first = code;
            m_hold = v && !r;
            m_d = d; m_l = l; m_k = k; m_s = s;
            e = {|hits, code, m_flags, m_first};
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input logic c, input string tag);
        step(1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 4'hF, 4'h0, c, tag);
    endtask

    task automatic check_ns(input logic [3:0] exp_flags, input string tag);
        n_tests++;
        if (ns_flags !== exp_flags) begin
            n_fail++;
            $display("FAIL %s: data-mask-free flags got %b expected %b", tag, ns_flags, exp_flags);
        end
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R10: reset state, bus ignored while held
        step(1'b0, 1'b1, 1'b0, 1'b0, 32'h1, 4'h0, 4'hF, 1'b0, "R10 reset bus ignored");
        step(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 4'hF, 4'h0, 1'b0, "R10 reset state");
        idle(1'b0, "R10 idle after reset");

        // R1: back-to-back transfers with changing data
        step(1'b1, 1'b1, 1'b1, 1'b0, 32'hA0, 4'hF, 4'hF, 1'b0, "R1 xfer a");
        step(1'b1, 1'b1, 1'b1, 1'b0, 32'hA1, 4'hF, 4'h3, 1'b0, "R1 xfer b");
        step(1'b1, 1'b1, 1'b1, 1'b1, 32'hA2, 4'hF, 4'hF, 1'b0, "R1 xfer last");

        // R2: stall with stable hold, then payload change
        step(1'b1, 1'b1, 1'b0, 1'b0, 32'hB0, 4'hF, 4'hF, 1'b0, "R2 stall start");
        step(1'b1, 1'b1, 1'b0, 1'b0, 32'hB0, 4'hF, 4'hF, 1'b0, "R2 stall stable");
        step(1'b1, 1'b1, 1'b1, 1'b0, 32'hB1, 4'hF, 4'hF, 1'b0, "R2 payload changed");
        // R2: end marker change under stall, then valid drop
        step(1'b1, 1'b1, 1'b0, 1'b0, 32'hC0, 4'hF, 4'hF, 1'b0, "R2 stall2");
        step(1'b1, 1'b1, 1'b0, 1'b1, 32'hC0, 4'hF, 4'hF, 1'b0, "R2 end changed");
        step(1'b1, 1'b0, 1'b1, 1'b1, 32'hC0, 4'hF, 4'hF, 1'b0, "R2 valid dropped");
        // R2: strobe change under stall
        step(1'b1, 1'b1, 1'b0, 1'b1, 32'hC1, 4'hF, 4'h1, 1'b0, "R2 stall3");
        step(1'b1, 1'b1, 1'b1, 1'b1, 32'hC1, 4'hF, 4'h3, 1'b0, "R2 strobe changed");

        // R8/R9: clear then fresh first code
        idle(1'b1, "R8 clear");
        // R3: illegal pair on a valid last beat (lane 0 unoccupied)
        step(1'b1, 1'b1, 1'b1, 1'b1, 32'hD0, 4'hE, 4'h1, 1'b0, "R3 illegal pair");
        // R3: same pattern with valid low
        step(1'b1, 1'b0, 1'b1, 1'b1, 32'hD0, 4'hE, 4'h1, 1'b0, "R3 invalid beat quiet");
        // R4: null lane in middle before end
        step(1'b1, 1'b1, 1'b1, 1'b0, 32'hD1, 4'hB, 4'h0, 1'b0, "R4 null before end");
        // R4: null high lane on last beat is fine
        step(1'b1, 1'b1, 1'b1, 1'b1, 32'hD2, 4'h7, 4'h7, 1'b0, "R4 null on last ok");
        // R5: empty beat on last, and before end (codes 3 and 4)
        step(1'b1, 1'b1, 1'b1, 1'b1, 32'hD3, 4'h0, 4'h0, 1'b0, "R5 empty last");
        step(1'b1, 1'b1, 1'b1, 1'b0, 32'hD4, 4'h0, 4'h0, 1'b0, "R5 empty mid");
        // R7: pair + null together, smallest code wins
        step(1'b1, 1'b1, 1'b1, 1'b0, 32'hD5, 4'h7, 4'h8, 1'b0, "R7 multi rule");
        // R8: violation on same edge as clear is kept
        step(1'b1, 1'b1, 1'b1, 1'b0, 32'hD6, 4'hE, 4'h0, 1'b1, "R8 clear with hit");
        idle(1'b0, "R9 first held");
        idle(1'b1, "R9 clear no hit");
        idle(1'b0, "R8 quiet after clear");

        // R10: stall before reset does not carry past it
        step(1'b1, 1'b1, 1'b0, 1'b0, 32'hE0, 4'hF, 4'hF, 1'b0, "R10 stall pre reset");
        step(1'b0, 1'b1, 1'b0, 1'b0, 32'hE0, 4'hF, 4'hF, 1'b0, "R10 reset mid stall");
        step(1'b1, 1'b1, 1'b1, 1'b0, 32'hE7, 4'hF, 4'hF, 1'b0, "R10 new data after reset");

        // R6: data mask ignored without it
        idle(1'b1, "R6 clear");
        step(1'b1, 1'b1, 1'b1, 1'b1, 32'hF0, 4'hE, 4'h1, 1'b0, "R6 pair main");
        step(1'b1, 1'b1, 1'b0, 1'b0, 32'hF1, 4'hF, 4'h0, 1'b0, "R6 stall");
        step(1'b1, 1'b1, 1'b1, 1'b0, 32'hF1, 4'hF, 4'h5, 1'b0, "R6 strobe moved");
        idle(1'b0, "R6 idle");
        idle(1'b0, "R6 idle2");
        check_ns(4'h0, "R6 no rules hit without data mask");

        idle(1'b0, "flush");
        @(negedge clk);
        monitor_pop();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule